// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Request Network

This block connects N requesters to N memory ports through log2(N) ranks of two-by-two switching cells, N/2 cells per rank. A requester presents a request with a destination port index and a data word. The route is decided entirely by the destination index: each rank looks at one bit of it, most significant bit in the first rank. A rotate-left of the line index (perfect shuffle) comes before every rank, and the cell sends the request to its upper output when the examined bit is 0 and to its lower output when it is 1. After the last rank the request sits on the memory port that equals its destination. Routing is purely combinational, so a request reaches its memory port in the cycle it is presented.

When two live requests in one cell want the same output, one goes on and the other is dropped. Each cell holds a priority bit that is cleared by reset (the upper input wins) and flips after every collision in that cell, so two sources that keep colliding there win in turn. One cycle after a request, its requester sees a one-cycle grant pulse if the request reached its memory port, or a one-cycle nack pulse if it was dropped. A nacked requester may present the request again.

The request side follows valid/ready rules with a deferred ready. A request counts only in a cycle where its valid bit is high. The grant or nack for it arrives in the next cycle, and nothing is held inside the block. A requester that keeps valid high presents a fresh request in each cycle. The memory ports apply no back-pressure: a memory-side valid is a one-cycle strobe that the port must take.

Top module: `omega_route_net`

## Requirements
- R1: After reset no grant or nack is active, and every cell gives the upper input (the input on the even shuffled line) the win at its first collision.
- R2: A request that is not dropped appears in the same cycle on the memory port whose index equals its destination. It carries its data word and its source index. Rank k examines destination bit log2(N)-1-k, and before each rank the line index is rotated left by one bit.
- R3: In the cycle after a requester asserts valid, exactly one of its grant and nack is high, for one cycle. Neither is high in a cycle that does not follow a request from that requester.
- R4: When all N requesters send to distinct ports given by destination = (source + s) mod N, every request is granted in the same cycle, for every shift s.
- R5: When two live requests in one cell want the same output, exactly one leaves that cell. The other is nacked and appears on no memory port.
- R6: A cell's priority flips after each collision in that cell and holds in cycles without one, so two sources that collide there repeatedly win alternately.
- R7: When all N requesters target one port in the same cycle, exactly one is granted and N-1 are nacked.
- R8: A requester that was nacked and then sends the same request with no other request active is granted.
- R9: A memory-side valid is high only while that port carries a request whose destination equals the port index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Request present, one bit per requester |
| req_dest | input | N*log2(N) | Destination port index per requester, requester i in bits [i*log2(N) +: log2(N)] |
| req_data | input | N*DW | Data word per requester, requester i in bits [i*DW +: DW] |
| grant_o | output | N | One-cycle pulse: the previous cycle's request was delivered |
| nack_o | output | N | One-cycle pulse: the previous cycle's request was dropped |
| mem_valid | output | N | Memory port p carries a request this cycle |
| mem_src | output | N*log2(N) | Source index of the request on each memory port |
| mem_data | output | N*DW | Data word on each memory port |

## Verification
The assertions assume that the destination and data fields are meaningful only where the matching valid bit is high, and that the requesters drive valid only after reset has been released. The bench changes its inputs only on falling edges, holds each request for exactly one cycle, and keeps every destination within 0..N-1. It compares the memory ports in the same cycle and the grant and nack pulses one edge later against an arithmetic model of the shuffle path. That model keeps its own priority bit for every cell. The fixed priority sequences are checked right after reset, before any other collisions have changed the priority bits.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect-shuffle wiring: rotate a line index left by one within 'bits' bits.
  function automatic int shuffle_idx(input int idx, input int bits);
    int mask;
    mask = (1 << bits) - 1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int PW     = 22,
  parameter int BITPOS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_v,
  input  logic [PW-1:0] a_p,
  input  logic          b_v,
  input  logic [PW-1:0] b_p,
  output logic          o0_v,
  output logic [PW-1:0] o0_p,
  output logic          o1_v,
  output logic [PW-1:0] o1_p
);

  logic a_bit, b_bit, clash, drop_a, drop_b, keep_a, keep_b;
  logic a_up, a_dn, b_up, b_dn;
  logic pri_q;

  assign a_bit  = a_p[BITPOS];
  assign b_bit  = b_p[BITPOS];
  assign clash  = a_v & b_v & (a_bit == b_bit);
  // pri_q = 0: upper input wins a collision; 1: lower input wins.
  assign drop_a = clash & pri_q;
  assign drop_b = clash & ~pri_q;
  assign keep_a = a_v & ~drop_a;
  assign keep_b = b_v & ~drop_b;

  assign a_up = keep_a & ~a_bit;
  assign a_dn = keep_a &  a_bit;
  assign b_up = keep_b & ~b_bit;
  assign b_dn = keep_b &  b_bit;

  assign o0_v = a_up | b_up;
  assign o0_p = a_up ? a_p : b_p;
  assign o1_v = a_dn | b_dn;
  assign o1_p = a_dn ? a_p : b_p;

  always_ff @(posedge clk) begin
    if (!rst_n)     pri_q <= 1'b0;
    else if (clash) pri_q <= ~pri_q;
  end

  // R5: a collision lets exactly one request out of the cell
  p_clash_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> ($countones({o0_v, o1_v}) == 1));

  // R5: a cell never creates requests
  p_no_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({o0_v, o1_v}) <= $countones({a_v, b_v}));

  // R6: priority flips after a collision
  p_clash_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> (pri_q != $past(pri_q)));

  // R6: priority holds without a collision
  p_calm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clash |=> $stable(pri_q));

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N   = 8,
  parameter int AW  = 3,
  parameter int DW  = 16,
  parameter int PW  = 2 * AW + DW,
  parameter int STG = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v  [N],
  input  logic [PW-1:0] in_p  [N],
  output logic          out_v [N],
  output logic [PW-1:0] out_p [N]
);
  import omega_pkg::*;

  // Destination field sits just above the data word; rank STG uses bit AW-1-STG.
  localparam int SELBIT = DW + AW - 1 - STG;

  logic          sh_v [N];
  logic [PW-1:0] sh_p [N];

  for (genvar p = 0; p < N; p++) begin : g_shuf
    localparam int Q = shuffle_idx(p, AW);
    assign sh_v[Q] = in_v[p];
    assign sh_p[Q] = in_p[p];
  end

  for (genvar j = 0; j < N / 2; j++) begin : g_cell
    omega_switch #(.PW(PW), .BITPOS(SELBIT)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .a_v  (sh_v[2*j]),
      .a_p  (sh_p[2*j]),
      .b_v  (sh_v[2*j+1]),
      .b_p  (sh_p[2*j+1]),
      .o0_v (out_v[2*j]),
      .o0_p (out_p[2*j]),
      .o1_v (out_v[2*j+1]),
      .o1_p (out_p[2*j+1])
    );
  end

endmodule

// File: rtl/omega_route_net.sv
module omega_route_net #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [N*AW-1:0] req_dest,
  input  logic [N*DW-1:0] req_data,
  output logic [N-1:0]    grant_o,
  output logic [N-1:0]    nack_o,
  output logic [N-1:0]    mem_valid,
  output logic [N*AW-1:0] mem_src,
  output logic [N*DW-1:0] mem_data
);

  localparam int S  = AW;
  localparam int PW = 2 * AW + DW;

  // Line state between ranks; payload = {source, destination, data}.
  logic          lv [S+1][N];
  logic [PW-1:0] lp [S+1][N];
  logic [N-1:0]  arrived;
  logic [N-1:0]  grant_q, nack_q;

  for (genvar i = 0; i < N; i++) begin : g_in
    assign lv[0][i] = req_valid[i];
    assign lp[0][i] = {AW'(i), req_dest[i*AW +: AW], req_data[i*DW +: DW]};
  end

  for (genvar k = 0; k < S; k++) begin : g_rank
    omega_stage #(.N(N), .AW(AW), .DW(DW), .PW(PW), .STG(k)) u_rank (
      .clk  (clk),
      .rst_n(rst_n),
      .in_v (lv[k]),
      .in_p (lp[k]),
      .out_v(lv[k+1]),
      .out_p(lp[k+1])
    );
  end

  for (genvar d = 0; d < N; d++) begin : g_out
    assign mem_valid[d]          = lv[S][d];
    assign mem_src[d*AW +: AW]   = lp[S][d][PW-1 -: AW];
    assign mem_data[d*DW +: DW]  = lp[S][d][DW-1:0];

    // R9: a delivered request sits on the port equal to its destination
    p_dest_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lv[S][d] |-> (lp[S][d][DW +: AW] == AW'(d)));

    // R2: a delivered request comes from a requester that is asking now
    p_src_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lv[S][d] |-> req_valid[lp[S][d][PW-1 -: AW]]);
  end

  always_comb begin
    arrived = '0;
    for (int d = 0; d < N; d++) begin
      if (lv[S][d]) arrived[lp[S][d][PW-1 -: AW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      nack_q  <= '0;
    end else begin
      grant_q <= arrived & req_valid;
      nack_q  <= req_valid & ~arrived;
    end
  end

  assign grant_o = grant_q;
  assign nack_o  = nack_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3: any response follows a request from the same requester
    p_resp_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[i] | nack_o[i]) |-> $past(req_valid[i]));

    // R3: a request is always answered in the next cycle
    p_req_answered_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] |=> (grant_o[i] ^ nack_o[i]));
  end

  // R7: never more grants than requests of the previous cycle
  p_grant_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) <= $countones($past(req_valid)));

endmodule

// File: tb/omega_route_net_tb.sv
`timescale 1ns/1ps
module omega_route_net_tb;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*AW-1:0] req_dest = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [N-1:0]    grant_o, nack_o, mem_valid;
  logic [N*AW-1:0] mem_src;
  logic [N*DW-1:0] mem_data;

  omega_route_net #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_data(req_data), .grant_o(grant_o), .nack_o(nack_o),
    .mem_valid(mem_valid), .mem_src(mem_src), .mem_data(mem_data));

  always #2 clk = ~clk;

  int nchk = 0, nbad = 0, seq = 0;
  int mpri [AW][N/2];
  logic [N-1:0] tb_v;
  int tb_d [N];
  logic [N-1:0] exp_win;

  task automatic chk(input string rq, input bit ok, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] word(input int s, input int d, input int n);
    return DW'(s * 4099 + d * 37 + n * 11 + 5);
  endfunction

  // Arithmetic model of the shuffle path with per-cell priority bits.
  task automatic model(output logic [N-1:0] win, output int at_port [N]);
    int pos [N];
    int np [N];
    bit live [N];
    for (int i = 0; i < N; i++) begin live[i] = tb_v[i]; pos[i] = i; end
    for (int k = 0; k < AW; k++) begin
      for (int i = 0; i < N; i++) begin
        pos[i] = ((pos[i] << 1) | (pos[i] >> (AW - 1))) & (N - 1);
        np[i]  = (pos[i] & ~1) | ((tb_d[i] >> (AW - 1 - k)) & 1);
      end
      for (int i = 0; i < N; i++) begin
        for (int j = i + 1; j < N; j++) begin
          if (live[i] && live[j] && np[i] == np[j]) begin
            int sw;
            int up, dn;
            sw = pos[i] >> 1;
            up = ((pos[i] & 1) == 0) ? i : j;
            dn = ((pos[i] & 1) == 0) ? j : i;
            if (mpri[k][sw] == 0) live[dn] = 0; else live[up] = 0;
            mpri[k][sw] = 1 - mpri[k][sw];
          end
        end
      end
      for (int i = 0; i < N; i++) pos[i] = np[i];
    end
    win = '0;
    for (int p = 0; p < N; p++) at_port[p] = -1;
    for (int i = 0; i < N; i++) if (live[i]) begin win[i] = 1'b1; at_port[pos[i]] = i; end
  endtask

  // Present tb_v/tb_d for one cycle; check memory ports, then responses.
  task automatic apply(input string rq);
    int at_port [N];
    @(negedge clk);
    seq++;
    req_valid = tb_v;
    for (int i = 0; i < N; i++) begin
      req_dest[i*AW +: AW] = AW'(tb_d[i]);
      req_data[i*DW +: DW] = word(i, tb_d[i], seq);
    end
    model(exp_win, at_port);
    #1;
    for (int p = 0; p < N; p++) begin
      chk({rq, " R9 port valid"}, mem_valid[p] == (at_port[p] >= 0), int'(mem_valid[p]), int'(at_port[p] >= 0));
      if (at_port[p] >= 0) begin
        chk({rq, " R2 port src"}, int'(mem_src[p*AW +: AW]) == at_port[p], int'(mem_src[p*AW +: AW]), at_port[p]);
        chk({rq, " R2 port data"}, mem_data[p*DW +: DW] == word(at_port[p], p, seq),
            int'(mem_data[p*DW +: DW]), int'(word(at_port[p], p, seq)));
      end
    end
    @(posedge clk);
    #1;
    chk({rq, " R3 grant"}, grant_o == exp_win, int'(grant_o), int'(exp_win));
    chk({rq, " R3 nack"}, nack_o == (tb_v & ~exp_win), int'(nack_o), int'(tb_v & ~exp_win));
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = '0;
    @(posedge clk);
    #1;
    chk("R3 idle no grant", grant_o == '0, int'(grant_o), 0);
    chk("R3 idle no nack", nack_o == '0, int'(nack_o), 0);
  endtask

  initial begin
    #(200000 * 4);
    nbad++;
    $display("FAIL watchdog act=%0d exp=%0d", nchk, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [N-1:0] first_nack;
    for (int k = 0; k < AW; k++) for (int j = 0; j < N/2; j++) mpri[k][j] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset grant", grant_o == '0, int'(grant_o), 0);
    chk("R1 reset nack", nack_o == '0, int'(nack_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R6: sources 0 and 4 collide in rank 0, cell 0; upper (source 0) first, then alternate
    for (int r = 0; r < 4; r++) begin
      tb_v = '0; tb_v[0] = 1'b1; tb_v[4] = 1'b1;
      for (int i = 0; i < N; i++) tb_d[i] = 0;
      apply("R6 pair");
      chk("R1 R6 alternating winner src0", grant_o[0] == ((r % 2) == 0), int'(grant_o[0]), int'((r % 2) == 0));
      chk("R5 R6 alternating winner src4", grant_o[4] == ((r % 2) == 1), int'(grant_o[4]), int'((r % 2) == 1));
    end
    idle_check();

    // R2: every single source to every destination
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        tb_v = '0; tb_v[s] = 1'b1;
        for (int i = 0; i < N; i++) tb_d[i] = d;
        apply("R2 single");
        chk("R2 single granted", grant_o[s] == 1'b1, int'(grant_o[s]), 1);
      end
    end
    idle_check();

    // R4: uniform shift permutations pass without loss
    for (int sh = 0; sh < N; sh++) begin
      tb_v = '1;
      for (int i = 0; i < N; i++) tb_d[i] = (i + sh) % N;
      apply("R4 shift");
      chk("R4 all granted", grant_o == '1, int'(grant_o), int'({N{1'b1}}));
    end

    // R7/R8: all to one port, then each nacked source retries alone
    for (int d = 0; d < N; d++) begin
      tb_v = '1;
      for (int i = 0; i < N; i++) tb_d[i] = d;
      apply("R7 hotspot");
      chk("R7 one grant", $countones(grant_o) == 1, $countones(grant_o), 1);
      chk("R5 R7 nacks", $countones(nack_o) == N - 1, $countones(nack_o), N - 1);
      first_nack = nack_o;
      for (int i = 0; i < N; i++) begin
        if (first_nack[i]) begin
          tb_v = '0; tb_v[i] = 1'b1;
          apply("R8 retry");
          chk("R8 retry granted", grant_o[i] == 1'b1, int'(grant_o[i]), 1);
        end
      end
    end
    idle_check();

    // R3/R5: pseudo-random masks and destinations against the model
    lf = 32'h1ace_b00c;
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < N; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        tb_d[i] = int'(lf[AW-1:0]);
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      tb_v = lf[N+3:4];
      apply("R5 random");
    end
    idle_check();

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule